// File: doc/BRIEF.md
# Launch Gate Sequencer

The launch gate sits between a packet front end and the workgroup dispatcher. It takes one ready task at a time and decides whether that task can launch. A task arrives with its queue id, the address of the queue's read pointer, the private bytes each work item needs, and the number of packets in flight on that queue. The sequencer first reads the word just past the read pointer. That word holds the distance from the descriptor base to the read pointer. The sequencer subtracts it to find the descriptor base, then copies the whole descriptor into a local buffer.

With the copy in hand, the sequencer compares the private demand against the scratch budget. The budget is the descriptor's scratch-size field times 1024 bytes. If the task fits, it goes to the dispatcher along with the queue id, the descriptor base and the descriptor copy. If it does not fit, the sequencer writes 1 into the value word of the queue's inactive signal, asking host software to grow the allocation. It then re-reads that word after a long pause for as long as the word is non-zero. Once the word reads zero, it fetches the descriptor again and repeats the check. If scratch is short while more than one packet is in flight on the queue, growing the allocation would be unsafe. The sequencer then raises a fatal flag and halts until reset.

States: IDLE (wait for a task), RD_OFS (read the base offset), RD_DESC (copy descriptor words), CHECK (compare demand with budget), WR_SIG (raise the host signal), POLL_WAIT (delay timer), RD_SIG (read the signal), DISPATCH (offer the task), FATAL (halted). Transitions: IDLE→RD_OFS on an accepted task; RD_OFS→RD_DESC on the response; RD_DESC→RD_DESC per word and →CHECK after the last word; CHECK→DISPATCH when the task fits, →FATAL when short with more than one packet in flight, →WR_SIG otherwise; WR_SIG→POLL_WAIT on the response; POLL_WAIT→RD_SIG when the timer expires; RD_SIG→POLL_WAIT on a non-zero value and →RD_DESC on zero; DISPATCH→IDLE on dispatcher ready; FATAL stays until reset.

Top module: `launch_gate`

## Requirements
- R1: `task_ready` is high only in IDLE. A task is taken only when `task_valid` and `task_ready` are both high at a clock edge. `task_valid` while busy is ignored and does not queue a second task.
- R2: The first memory request after a task is a read at `task_rdptr + RDPTR_BYTES`. The descriptor base is `task_rdptr` minus the returned value and appears on `disp_base`.
- R3: Before any decision, the sequencer reads `DESC_WORDS` words at `base + 4*i` for i = 0, 1, 2, ... in ascending order. Word `SCR_WORD` (1) holds the scratch-size field and word `SIG_WORD` (2) holds the signal handle. `disp_desc` carries word i in bits `[32*i+31:32*i]`.
- R4: A task fits when `task_priv <= scratch_field * 1024`, with equality counting as a fit. A fitting task is dispatched with no signal write, whatever its in-flight count.
- R5: When a task does not fit and `task_inflight <= 1`, the sequencer writes value 1 (`mem_req_write` = 1) at the signal handle plus `SIG_VAL_OFS` (8).
- R6: When a task does not fit and `task_inflight > 1`, `err_fatal` rises and stays high until reset. There is no signal write and no dispatch.
- R7: After the signal write, and after every non-zero signal read, at least `POLL_DLY` cycles pass with no memory request before the next signal read.
- R8: A signal read returning zero triggers a fresh read of every descriptor word and a new check. The write–poll–refetch loop repeats until the task fits.
- R9: Only one request is outstanding at a time. `mem_req_valid`, address, direction and write data stay stable until `mem_rsp_valid`. The next request is issued no earlier than the following cycle.
- R10: `disp_valid` stays high with stable `disp_qid`, `disp_base` and `disp_desc` until `disp_ready`. It drops in the cycle after acceptance, and the sequencer returns to IDLE.
- R11: Synchronous active-high `rst` returns the sequencer to IDLE with no request, no dispatch and no fatal flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| task_valid | input | 1 | A task is offered |
| task_ready | output | 1 | Sequencer is idle and takes the task |
| task_qid | input | QW | Queue id of the task |
| task_rdptr | input | AW | Byte address of the queue read pointer |
| task_priv | input | PW | Private bytes needed per work item |
| task_inflight | input | IFW | Packets in flight on the queue |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Request byte address |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Response or write acknowledge, one cycle |
| mem_rsp_data | input | DW | Read data |
| disp_valid | output | 1 | Task ready for the dispatcher |
| disp_ready | input | 1 | Dispatcher takes the task |
| disp_qid | output | QW | Queue id of the dispatched task |
| disp_base | output | AW | Descriptor base address |
| disp_desc | output | DESC_WORDS*DW | Local descriptor copy |
| err_fatal | output | 1 | Scratch short with packets in flight; sticky |

## Verification
The assertions assume the memory side answers every request with exactly one `mem_rsp_valid` pulse. They also assume it never answers when no request is pending. The bench's memory model obeys both: it starts a transaction only when it is neither busy nor answering, and it responds after a fixed latency. The gap property assumes the sequencer's own request line is the only source of memory traffic. The host model in the bench clears the signal only after a set number of non-zero reads, and it grows the scratch field by a fixed step. That keeps every stimulus case finite and predictable.

// File: rtl/launch_gate_pkg.sv
package launch_gate_pkg;

    // Scratch budget granule: one field unit stands for 2**SCRATCH_SHIFT bytes.
    localparam int SCRATCH_SHIFT = 10;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_OFS,
        ST_RD_DESC,
        ST_CHECK,
        ST_WR_SIG,
        ST_POLL_WAIT,
        ST_RD_SIG,
        ST_DISPATCH,
        ST_FATAL
    } lg_state_e;

endpackage

// File: rtl/launch_gate_poll_timer.sv
module launch_gate_poll_timer #(
    parameter int POLL_DLY = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic done
);
    localparam int CW = (POLL_DLY > 1) ? $clog2(POLL_DLY + 1) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CW'(POLL_DLY - 1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0) && !load;

endmodule

// File: rtl/launch_gate_fit.sv
module launch_gate_fit #(
    parameter int PW = 32,
    parameter int DW = 32
) (
    input  logic [PW-1:0] priv_bytes,
    input  logic [DW-1:0] scratch_field,
    output logic          fits
);
    import launch_gate_pkg::*;

    localparam int SUMW = DW + SCRATCH_SHIFT;
    localparam int CW   = ((PW > SUMW) ? PW : SUMW) + 1;

    logic [CW-1:0] demand;
    logic [CW-1:0] budget;

    assign demand = CW'(priv_bytes);
    assign budget = CW'(scratch_field) << SCRATCH_SHIFT;
    assign fits   = (demand <= budget);

endmodule

// File: rtl/launch_gate.sv
module launch_gate #(
    parameter int QW          = 4,
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int PW          = 32,
    parameter int IFW         = 4,
    parameter int DESC_WORDS  = 4,
    parameter int SCR_WORD    = 1,
    parameter int SIG_WORD    = 2,
    parameter int RDPTR_BYTES = 8,
    parameter int SIG_VAL_OFS = 8,
    parameter int POLL_DLY    = 1024
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     task_valid,
    output logic                     task_ready,
    input  logic [QW-1:0]            task_qid,
    input  logic [AW-1:0]            task_rdptr,
    input  logic [PW-1:0]            task_priv,
    input  logic [IFW-1:0]           task_inflight,
    output logic                     mem_req_valid,
    output logic                     mem_req_write,
    output logic [AW-1:0]            mem_req_addr,
    output logic [DW-1:0]            mem_req_wdata,
    input  logic                     mem_rsp_valid,
    input  logic [DW-1:0]            mem_rsp_data,
    output logic                     disp_valid,
    input  logic                     disp_ready,
    output logic [QW-1:0]            disp_qid,
    output logic [AW-1:0]            disp_base,
    output logic [DESC_WORDS*DW-1:0] disp_desc,
    output logic                     err_fatal
);
    import launch_gate_pkg::*;

    localparam int WB   = DW / 8;
    localparam int IW   = (DESC_WORDS > 1) ? $clog2(DESC_WORDS) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(DESC_WORDS - 1);

    lg_state_e state_q, state_d;

    logic [QW-1:0]  qid_q;
    logic [AW-1:0]  rdptr_q;
    logic [PW-1:0]  priv_q;
    logic [IFW-1:0] infl_q;
    logic [AW-1:0]  base_q;
    logic [IW-1:0]  idx_q;
    logic [DW-1:0]  desc_q [DESC_WORDS];

    logic          fits;
    logic          tmr_load;
    logic          tmr_done;
    logic [AW-1:0] sig_addr;

    assign sig_addr = AW'(desc_q[SIG_WORD]) + AW'(SIG_VAL_OFS);

    launch_gate_fit #(.PW(PW), .DW(DW)) u_fit (
        .priv_bytes    (priv_q),
        .scratch_field (desc_q[SCR_WORD]),
        .fits          (fits)
    );

    launch_gate_poll_timer #(.POLL_DLY(POLL_DLY)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .done (tmr_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (task_valid) state_d = ST_RD_OFS;
            ST_RD_OFS:    if (mem_rsp_valid) state_d = ST_RD_DESC;
            ST_RD_DESC:   if (mem_rsp_valid && idx_q == LAST_IDX) state_d = ST_CHECK;
            ST_CHECK: begin
                if (fits)                      state_d = ST_DISPATCH;
                else if (infl_q > IFW'(1))     state_d = ST_FATAL;
                else                           state_d = ST_WR_SIG;
            end
            ST_WR_SIG:    if (mem_rsp_valid) state_d = ST_POLL_WAIT;
            ST_POLL_WAIT: if (tmr_done) state_d = ST_RD_SIG;
            ST_RD_SIG: begin
                if (mem_rsp_valid)
                    state_d = (mem_rsp_data == '0) ? ST_RD_DESC : ST_POLL_WAIT;
            end
            ST_DISPATCH:  if (disp_ready) state_d = ST_IDLE;
            ST_FATAL:     state_d = ST_FATAL;
            default:      state_d = ST_IDLE;
        endcase
    end

    assign tmr_load = (state_d == ST_POLL_WAIT) && (state_q != ST_POLL_WAIT);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Task, base and descriptor capture
    always_ff @(posedge clk) begin
        if (rst) begin
            qid_q   <= '0;
            rdptr_q <= '0;
            priv_q  <= '0;
            infl_q  <= '0;
            base_q  <= '0;
            idx_q   <= '0;
        end else begin
            if (state_q == ST_IDLE && task_valid) begin
                qid_q   <= task_qid;
                rdptr_q <= task_rdptr;
                priv_q  <= task_priv;
                infl_q  <= task_inflight;
            end
            if (state_q == ST_RD_OFS && mem_rsp_valid) begin
                base_q <= rdptr_q - AW'(mem_rsp_data);
                idx_q  <= '0;
            end
            if (state_q == ST_RD_DESC && mem_rsp_valid)
                idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
            if (state_q == ST_RD_SIG && mem_rsp_valid)
                idx_q <= '0;
        end
    end

    generate
        for (genvar gi = 0; gi < DESC_WORDS; gi++) begin : g_desc
            always_ff @(posedge clk) begin
                if (rst)
                    desc_q[gi] <= '0;
                else if (state_q == ST_RD_DESC && mem_rsp_valid && idx_q == IW'(gi))
                    desc_q[gi] <= mem_rsp_data;
            end
            assign disp_desc[gi*DW +: DW] = desc_q[gi];
        end
    endgenerate

    // Outputs
    always_comb begin
        task_ready    = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        disp_valid    = 1'b0;
        err_fatal     = 1'b0;
        unique case (state_q)
            ST_IDLE:    task_ready = 1'b1;
            ST_RD_OFS: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = rdptr_q + AW'(RDPTR_BYTES);
            end
            ST_RD_DESC: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = base_q + AW'(idx_q) * AW'(WB);
            end
            ST_WR_SIG: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = sig_addr;
                mem_req_wdata = DW'(1);
            end
            ST_RD_SIG: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = sig_addr;
            end
            ST_DISPATCH: disp_valid = 1'b1;
            ST_FATAL:    err_fatal  = 1'b1;
            default: ;
        endcase
    end

    assign disp_qid  = qid_q;
    assign disp_base = base_q;

endmodule

// File: rtl/launch_gate_chk.sv
module launch_gate_chk #(
    parameter int QW       = 4,
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int POLL_DLY = 1024
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        task_ready,
    input logic                        mem_req_valid,
    input logic                        mem_req_write,
    input logic [AW-1:0]               mem_req_addr,
    input logic [DW-1:0]               mem_req_wdata,
    input logic                        mem_rsp_valid,
    input logic                        disp_valid,
    input logic                        disp_ready,
    input logic [QW-1:0]               disp_qid,
    input logic [AW-1:0]               disp_base,
    input logic                        err_fatal,
    input launch_gate_pkg::lg_state_e  state
);
    import launch_gate_pkg::*;

    logic [31:0] idle_run;

    always_ff @(posedge clk) begin
        if (rst)                   idle_run <= '0;
        else if (mem_req_valid)    idle_run <= '0;
        else if (idle_run != '1)   idle_run <= idle_run + 1'b1;
    end

    p_idle_only_r1: assert property (@(posedge clk) disable iff (rst)
        task_ready |-> (!mem_req_valid && !disp_valid && !err_fatal));

    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_rsp_valid) |=>
            (mem_req_valid && $stable(mem_req_addr) &&
             $stable(mem_req_write) && $stable(mem_req_wdata)));

    p_write_one_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> (mem_req_wdata == DW'(1)));

    p_fatal_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        err_fatal |=> (err_fatal && !task_ready && !disp_valid));

    p_fatal_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        err_fatal |-> !mem_req_valid);

    p_poll_gap_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_req_valid) && state == ST_RD_SIG) |-> (idle_run >= 32'(POLL_DLY)));

    p_disp_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !disp_ready) |=>
            (disp_valid && $stable(disp_qid) && $stable(disp_base)));

    p_disp_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_ready) |=> (!disp_valid && task_ready));

endmodule

bind launch_gate launch_gate_chk #(
    .QW(QW), .AW(AW), .DW(DW), .POLL_DLY(POLL_DLY)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .task_ready    (task_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .disp_valid    (disp_valid),
    .disp_ready    (disp_ready),
    .disp_qid      (disp_qid),
    .disp_base     (disp_base),
    .err_fatal     (err_fatal),
    .state         (state_q)
);

// File: tb/launch_gate_tb.sv
module launch_gate_tb;

    localparam int QW = 4, AW = 32, DW = 32, PW = 32, IFW = 4, NW = 4;
    localparam int POLL_DLY = 1024;
    localparam int LAT = 2;
    localparam logic [AW-1:0] RDPTR   = 32'h40;
    localparam logic [AW-1:0] OFS_ADR = 32'h48;
    localparam logic [AW-1:0] HANDLE  = 32'h80;
    localparam logic [AW-1:0] SIG_ADR = 32'h88;

    typedef struct packed {
        logic [31:0] priv;
        logic [15:0] scr0;
        logic [15:0] step;
        logic [3:0]  infl;
        logic [7:0]  npoll;
        logic [7:0]  ofs;
        logic        fatal;
        logic [3:0]  writes;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{32'd100,  16'd1, 16'd0, 4'd0, 8'd0, 8'h40, 1'b0, 4'd0},
        '{32'd1024, 16'd1, 16'd0, 4'd1, 8'd0, 8'h30, 1'b0, 4'd0},
        '{32'd10,   16'd1, 16'd0, 4'd5, 8'd0, 8'h40, 1'b0, 4'd0},
        '{32'd1025, 16'd1, 16'd1, 4'd1, 8'd0, 8'h40, 1'b0, 4'd1},
        '{32'd3000, 16'd0, 16'd3, 4'd0, 8'd2, 8'h30, 1'b0, 4'd1},
        '{32'd4096, 16'd2, 16'd1, 4'd1, 8'd0, 8'h40, 1'b0, 4'd2},
        '{32'd5000, 16'd1, 16'd1, 4'd2, 8'd0, 8'h40, 1'b1, 4'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic               task_valid = 1'b0;
    logic               task_ready;
    logic [QW-1:0]      task_qid = '0;
    logic [AW-1:0]      task_rdptr = '0;
    logic [PW-1:0]      task_priv = '0;
    logic [IFW-1:0]     task_inflight = '0;
    logic               mem_req_valid, mem_req_write;
    logic [AW-1:0]      mem_req_addr;
    logic [DW-1:0]      mem_req_wdata;
    logic               mem_rsp_valid;
    logic [DW-1:0]      mem_rsp_data;
    logic               disp_valid;
    logic               disp_ready = 1'b1;
    logic [QW-1:0]      disp_qid;
    logic [AW-1:0]      disp_base;
    logic [NW*DW-1:0]   disp_desc;
    logic               err_fatal;

    launch_gate u_dut (
        .clk(clk), .rst(rst),
        .task_valid(task_valid), .task_ready(task_ready), .task_qid(task_qid),
        .task_rdptr(task_rdptr), .task_priv(task_priv), .task_inflight(task_inflight),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_qid(disp_qid),
        .disp_base(disp_base), .disp_desc(disp_desc), .err_fatal(err_fatal)
    );

    // Memory and host model configuration (driven by the stimulus process)
    logic        mon_clr = 1'b0;
    logic [31:0] cfg_scr0 = '0, cfg_step = '0;
    logic [7:0]  cfg_npoll = '0, cfg_ofs = 8'h40;

    // Model state and monitors
    logic        busy, rsp_v;
    logic [3:0]  lat;
    logic [31:0] cap_data, scr_cur, sig_val, pcnt;
    int          n_ofs, n_desc, n_swr, n_srd, n_disp, gap, min_gap;
    logic        order_bad;
    logic [31:0] last_wd;
    logic [QW-1:0]    cap_qid;
    logic [AW-1:0]    cap_base;
    logic [NW*DW-1:0] cap_desc;
    logic [AW-1:0]    mbase;

    assign mem_rsp_valid = rsp_v;
    assign mem_rsp_data  = cap_data;
    assign mbase = RDPTR - AW'(cfg_ofs);

    function automatic logic [31:0] rd_word(input logic [AW-1:0] a);
        if (a == OFS_ADR)                     return 32'(cfg_ofs);
        if (a == SIG_ADR)                     return sig_val;
        if (a == mbase)                       return 32'h0000_00A0;
        if (a == mbase + 4)                   return scr_cur;
        if (a == mbase + 8)                   return HANDLE;
        if (a == mbase + 12)                  return 32'h0000_00A3;
        return 32'hDEAD_BEEF;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            rsp_v <= 1'b0;
        end else begin
            rsp_v <= 1'b0;
            if (mem_req_valid && !busy && !rsp_v) begin
                busy     <= 1'b1;
                lat      <= 4'(LAT);
                cap_data <= rd_word(mem_req_addr);
                if (mem_req_write) begin
                    if (mem_req_addr == SIG_ADR) begin
                        n_swr   <= n_swr + 1;
                        last_wd <= mem_req_wdata;
                        if (cfg_npoll == 0) begin
                            sig_val <= 0;
                            scr_cur <= scr_cur + cfg_step;
                        end else begin
                            sig_val <= mem_req_wdata;
                            pcnt    <= 32'(cfg_npoll);
                        end
                    end
                end else if (mem_req_addr == OFS_ADR) begin
                    n_ofs <= n_ofs + 1;
                end else if (mem_req_addr == SIG_ADR) begin
                    n_srd <= n_srd + 1;
                    if (gap < min_gap) min_gap <= gap;
                    if (sig_val != 0) begin
                        pcnt <= pcnt - 1;
                        if (pcnt <= 1) begin
                            sig_val <= 0;
                            scr_cur <= scr_cur + cfg_step;
                        end
                    end
                end else begin
                    if (mem_req_addr != mbase + AW'(4 * (n_desc % NW))) order_bad <= 1'b1;
                    n_desc <= n_desc + 1;
                end
            end else if (busy) begin
                if (lat == 0) begin
                    rsp_v <= 1'b1;
                    busy  <= 1'b0;
                end else begin
                    lat <= lat - 1;
                end
            end
            gap <= mem_req_valid ? 0 : gap + 1;
            if (disp_valid && disp_ready) begin
                n_disp   <= n_disp + 1;
                cap_qid  <= disp_qid;
                cap_base <= disp_base;
                cap_desc <= disp_desc;
            end
        end
        if (mon_clr) begin
            n_ofs <= 0; n_desc <= 0; n_swr <= 0; n_srd <= 0; n_disp <= 0;
            gap <= 0; min_gap <= 32'h7FFF_FFFF; order_bad <= 1'b0; last_wd <= '0;
            scr_cur <= cfg_scr0; sig_val <= '0; pcnt <= '0;
            cap_qid <= '0; cap_base <= '0; cap_desc <= '0;
        end
    end

    // Check bookkeeping
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; mon_clr = 1'b1; task_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0; mon_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic setup(input vec_t v);
        cfg_scr0 = 32'(v.scr0); cfg_step = 32'(v.step);
        cfg_npoll = v.npoll; cfg_ofs = v.ofs;
        do_reset();
    endtask

    task automatic offer(input logic [QW-1:0] q, input logic [PW-1:0] p, input logic [IFW-1:0] f);
        task_qid = q; task_rdptr = RDPTR; task_priv = p; task_inflight = f;
        task_valid = 1'b1;
        @(negedge clk);
        task_valid = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 20000; i++) begin
            if (n_disp != 0 || err_fatal) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        // R11: state right after reset
        setup(VECS[0]);
        chk(task_ready == 1'b1, "R11", "ready after reset", 64'(task_ready), 1);
        chk(!mem_req_valid && !disp_valid && !err_fatal, "R11", "quiet after reset",
            {61'b0, mem_req_valid, disp_valid, err_fatal}, 0);

        // Table-driven launches
        for (int k = 0; k < 7; k++) begin
            vec_t v = VECS[k];
            int exp_rd;
            logic [AW-1:0] eb;
            setup(v);
            eb = RDPTR - AW'(v.ofs);
            exp_rd = int'(v.writes) * (int'(v.npoll) + 1);
            offer(4'(k + 1), v.priv, v.infl);
            wait_end();
            chk(err_fatal == v.fatal, v.fatal ? "R6" : "R4", "outcome", 64'(err_fatal), 64'(v.fatal));
            chk(n_ofs == 1, "R2", "offset reads", 64'(n_ofs), 1);
            chk(n_desc == NW * (1 + int'(v.writes)), "R8", "descriptor reads",
                64'(n_desc), 64'(NW * (1 + int'(v.writes))));
            chk(!order_bad, "R3", "descriptor order", 64'(order_bad), 0);
            chk(n_swr == int'(v.writes), "R5", "signal writes", 64'(n_swr), 64'(v.writes));
            chk(n_srd == exp_rd, "R8", "signal reads", 64'(n_srd), 64'(exp_rd));
            if (v.writes != 0) begin
                chk(last_wd == 32'd1, "R5", "signal value", 64'(last_wd), 1);
                chk(min_gap >= POLL_DLY, "R7", "poll gap", 64'(min_gap), 64'(POLL_DLY));
            end
            if (v.fatal) begin
                chk(n_disp == 0 && task_ready == 1'b0, "R6", "halted",
                    {32'(n_disp), 31'b0, task_ready}, 0);
                repeat (20) @(negedge clk);
                chk(err_fatal == 1'b1, "R6", "sticky", 64'(err_fatal), 1);
            end else begin
                chk(n_disp == 1, "R4", "dispatch count", 64'(n_disp), 1);
                chk(cap_qid == 4'(k + 1), "R4", "dispatch qid", 64'(cap_qid), 64'(k + 1));
                chk(cap_base == eb, "R2", "descriptor base", 64'(cap_base), 64'(eb));
                chk(cap_desc[63:32] == 32'(v.scr0) + 32'(v.writes) * 32'(v.step), "R3",
                    "scratch word in copy", 64'(cap_desc[63:32]),
                    64'(32'(v.scr0) + 32'(v.writes) * 32'(v.step)));
                chk(cap_desc[95:64] == HANDLE, "R3", "handle word in copy",
                    64'(cap_desc[95:64]), 64'(HANDLE));
                chk(task_ready == 1'b1, "R10", "back to idle", 64'(task_ready), 1);
            end
        end

        // R11: reset clears a fatal halt
        do_reset();
        chk(!err_fatal && task_ready, "R11", "fatal cleared by reset",
            {62'b0, err_fatal, task_ready}, 1);

        // R1: a task offered while busy is ignored
        setup('{32'd1025, 16'd1, 16'd1, 4'd1, 8'd1, 8'h40, 1'b0, 4'd1});
        offer(4'd5, 32'd1025, 4'd1);
        repeat (30) @(negedge clk);
        chk(task_ready == 1'b0, "R1", "busy not ready", 64'(task_ready), 0);
        task_qid = 4'd9; task_priv = 32'd1; task_valid = 1'b1;
        repeat (10) @(negedge clk);
        task_valid = 1'b0;
        wait_end();
        repeat (20) @(negedge clk);
        chk(n_disp == 1, "R1", "one dispatch only", 64'(n_disp), 1);
        chk(cap_qid == 4'd5, "R1", "first task kept", 64'(cap_qid), 5);
        chk(n_ofs == 1, "R1", "no second fetch", 64'(n_ofs), 1);

        // R10: dispatcher back-pressure
        setup(VECS[0]);
        disp_ready = 1'b0;
        offer(4'd7, 32'd8, 4'd0);
        for (int i = 0; i < 200; i++) begin
            if (disp_valid) break;
            @(negedge clk);
        end
        repeat (5) @(negedge clk);
        chk(disp_valid && disp_qid == 4'd7, "R10", "held under back-pressure",
            {59'b0, disp_valid, disp_qid}, {59'b0, 1'b1, 4'd7});
        disp_ready = 1'b1;
        @(negedge clk);
        chk(!disp_valid && task_ready, "R10", "drop after accept",
            {62'b0, disp_valid, task_ready}, 1);
        chk(n_disp == 1, "R10", "single acceptance", 64'(n_disp), 1);

        // R11: reset in the middle of polling
        setup('{32'd2000, 16'd1, 16'd1, 4'd0, 8'd5, 8'h40, 1'b0, 4'd1});
        offer(4'd3, 32'd2000, 4'd0);
        repeat (100) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(task_ready && !mem_req_valid && !disp_valid && !err_fatal, "R11",
            "mid-run reset", {60'b0, task_ready, mem_req_valid, disp_valid, err_fatal}, 64'h8);
        repeat (20) @(negedge clk);
        chk(!mem_req_valid, "R11", "stays idle", 64'(mem_req_valid), 0);

        finished = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule